// File: doc/BRIEF.md
# Pull-Based Tile Message Engine

This engine sits in one tile of a memory-mapped on-chip network and moves short messages between a sending tile and a receiving tile. The data never travels as a push. To send, the local core names a destination and a length and then streams the words. The engine stores those words in an outbox slice of its own tile memory that belongs to that destination. It then makes a single remote write that raises a semaphore, together with a length header, inside the destination tile. The core is free again as soon as that write is answered. The destination slot stays marked pending until the receiver says it has finished, so a producer-consumer pair never has more than one message in flight.

On the receiving side, the engine polls its local semaphore bank. When one or more semaphores are raised and the core allows reception, a round-robin choice picks a source. The engine then pulls the message with one remote read per word from the source tile's outbox and hands each word to the core. After the last word it sends a notification write back to the source, which frees that source's pending slot. The target network port is separate from the initiator port and is always ready, so a tile keeps serving remote reads of its outbox while its own requests are outstanding.

Network addresses are `{tile[3:0], region[1:0], offset[7:0]}`. The regions are: 0 = outbox, where offset = consumer_id*16 + word index; 1 = semaphore and header, where offset = source id; 2 = notification, where offset = source id.

The sending state machine has four states:
- SND_IDLE goes to SND_LOAD when a send is accepted.
- SND_LOAD goes to SND_SIGNAL when the last word is written.
- SND_SIGNAL goes to SND_WAIT when the semaphore write is granted.
- SND_WAIT goes to SND_IDLE when the response arrives.

The receiving state machine has five states:
- RCV_IDLE goes to RCV_READ when a semaphore is picked.
- RCV_READ goes to RCV_WAIT_RD when a read is granted.
- RCV_WAIT_RD goes back to RCV_READ when a response arrives and more words remain. It goes to RCV_NOTIFY when the last word is in.
- RCV_NOTIFY goes to RCV_WAIT_NT when the notification is granted.
- RCV_WAIT_NT goes to RCV_IDLE when the response arrives.

Top module: `msg_engine`

## Requirements
- R1: After reset, pend_mask is zero, ini_req_valid is low, rx_valid is low and tgt_rsp_valid is low.
- R2: A send to a destination that is not pending, made while the sender is idle, is acknowledged in the same cycle with snd_busy low. pend_mask[dest] is set from the next cycle. The following snd_len accepted words are stored at outbox offset dest*16+i.
- R3: After the last word is stored, exactly one initiator write is issued, to address {dest, region 1, own id} with data equal to the length. No message word crosses the network from the sender.
- R4: A send to a pending destination, or any send while a previous send is still loading or signalling, shows snd_busy high and snd_ack low in the same cycle. It leaves the outbox unchanged and issues no network request.
- R5: A target write to region 2 at offset s clears pend_mask[s] from the next cycle. A new send to s is then accepted. Messages of 1 to 16 words are supported.
- R6: A target write to region 1 at offset s with data L raises semaphore s with length L. With rx_en high, the engine issues L reads to {s, region 0, own_id*16+i} for i = 0..L-1, in increasing order.
- R7: Each read response appears one cycle later as an rx_valid pulse carrying rx_src = s, rx_data equal to the response word, and rx_last high only on word L-1.
- R8: After the last word, exactly one initiator write is issued to {s, region 2, own id}.
- R9: When several semaphores are raised, sources are served in round-robin order. The search starts just above the source served last (after reset it starts at 0).
- R10: A target read of region 0 returns the stored outbox word, with tgt_rsp_valid high, in the cycle after the request. This holds even while the initiator port is busy.
- R11: At most one initiator request is outstanding. After a handshake, ini_req_valid stays low until the response has arrived.
- R12: While rx_en is low, no new receive transfer starts and raised semaphores are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tile_id | input | 4 | Identity of this tile |
| snd_req | input | 1 | Core asks to send a message |
| snd_dest | input | 4 | Destination tile of the send |
| snd_len | input | 5 | Message length in words, 1 to 16 |
| snd_ack | output | 1 | Send accepted (combinational) |
| snd_busy | output | 1 | Send refused: destination pending or sender active |
| snd_wvalid | input | 1 | Message word valid during loading |
| snd_wdata | input | 32 | Message word |
| pend_mask | output | 16 | One pending bit per destination |
| rx_en | input | 1 | Core allows a new receive transfer |
| rx_valid | output | 1 | Received word valid |
| rx_src | output | 4 | Source tile of the received word |
| rx_data | output | 32 | Received word |
| rx_last | output | 1 | Final word of the message |
| ini_req_valid | output | 1 | Initiator request valid |
| ini_req_ready | input | 1 | Network accepts the request |
| ini_req_write | output | 1 | 1 = write, 0 = read |
| ini_req_addr | output | 14 | Request address |
| ini_req_wdata | output | 32 | Write data |
| ini_rsp_valid | input | 1 | Response to the outstanding request |
| ini_rsp_rdata | input | 32 | Read data of the response |
| tgt_valid | input | 1 | Incoming request (always accepted) |
| tgt_write | input | 1 | 1 = write, 0 = read |
| tgt_addr | input | 14 | Incoming address |
| tgt_wdata | input | 32 | Incoming write data |
| tgt_rsp_valid | output | 1 | Response, one cycle after the request |
| tgt_rsp_rdata | output | 32 | Read data of the response |

## Verification
The assertions take the protocol partners to be well behaved. A notification arrives only for a destination that is pending, and never in the cycle its send is acknowledged. A semaphore write for a source arrives only while that source's semaphore is clear. Lengths stay between 1 and 16, and every granted initiator request receives exactly one response, no earlier than the next cycle. The bench plays the rest of the network to meet these rules. It answers each request one cycle after its handshake. It sends a notification only after the matching semaphore write has been seen. It raises a semaphore again only after the previous transfer from that source has sent its notification.

// File: rtl/msg_pkg.sv
package msg_pkg;

    typedef enum logic [1:0] {
        RGN_OUTBOX = 2'd0,
        RGN_SEM    = 2'd1,
        RGN_NOTIFY = 2'd2,
        RGN_SPARE  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_LOAD,
        SND_SIGNAL,
        SND_WAIT
    } snd_state_e;

    typedef enum logic [2:0] {
        RCV_IDLE,
        RCV_READ,
        RCV_WAIT_RD,
        RCV_NOTIFY,
        RCV_WAIT_NT
    } rcv_state_e;

endpackage

// File: rtl/msg_store.sv
module msg_store
    import msg_pkg::*;
#(
    parameter int NTILES    = 16,
    parameter int MAX_WORDS = 16,
    parameter int WORD_W    = 32,
    parameter int ID_W      = 4,
    parameter int LEN_W     = 5,
    parameter int OFF_W     = 8,
    parameter int ADDR_W    = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    tgt_valid,
    input  logic                    tgt_write,
    input  logic [ADDR_W-1:0]       tgt_addr,
    input  logic [WORD_W-1:0]       tgt_wdata,
    output logic                    tgt_rsp_valid,
    output logic [WORD_W-1:0]       tgt_rsp_rdata,
    output logic [NTILES-1:0]       sem_vec,
    output logic [NTILES*LEN_W-1:0] hdr_len_flat,
    input  logic                    sem_clr,
    input  logic [ID_W-1:0]         sem_clr_idx,
    output logic                    notify_valid,
    output logic [ID_W-1:0]         notify_src
);

    localparam int DEPTH = NTILES * MAX_WORDS;

    logic [WORD_W-1:0] mem [DEPTH];
    region_e           t_rgn;
    logic [OFF_W-1:0]  t_off;
    logic [ID_W-1:0]   t_src;
    logic              sem_wr;
    logic              unused_bits;

    assign t_rgn  = region_e'(tgt_addr[OFF_W +: 2]);
    assign t_off  = tgt_addr[OFF_W-1:0];
    assign t_src  = t_off[ID_W-1:0];
    assign sem_wr = tgt_valid && tgt_write && (t_rgn == RGN_SEM);
    assign unused_bits = ^{tgt_addr[ADDR_W-1:OFF_W+2], tgt_wdata[WORD_W-1:LEN_W]};

    assign notify_valid = tgt_valid && tgt_write && (t_rgn == RGN_NOTIFY);
    assign notify_src   = t_src;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_rsp_valid <= 1'b0;
            tgt_rsp_rdata <= '0;
        end else begin
            tgt_rsp_valid <= tgt_valid;
            tgt_rsp_rdata <= (tgt_valid && !tgt_write && t_rgn == RGN_OUTBOX) ? mem[t_off] : '0;
        end
    end

    for (genvar g = 0; g < NTILES; g++) begin : g_sem
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sem_vec[g]                      <= 1'b0;
                hdr_len_flat[g*LEN_W +: LEN_W]  <= '0;
            end else if (sem_wr && t_src == ID_W'(g)) begin
                sem_vec[g]                      <= 1'b1;
                hdr_len_flat[g*LEN_W +: LEN_W]  <= tgt_wdata[LEN_W-1:0];
            end else if (sem_clr && sem_clr_idx == ID_W'(g)) begin
                sem_vec[g]                      <= 1'b0;
            end
        end
    end

    AST_SEM_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        sem_wr |=> sem_vec[$past(t_src)]); // R6

endmodule

// File: rtl/msg_producer.sv
module msg_producer
    import msg_pkg::*;
#(
    parameter int NTILES = 16,
    parameter int WORD_W = 32,
    parameter int ID_W   = 4,
    parameter int WIX_W  = 4,
    parameter int LEN_W  = 5,
    parameter int OFF_W  = 8,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   tile_id,
    input  logic              snd_req,
    input  logic [ID_W-1:0]   snd_dest,
    input  logic [LEN_W-1:0]  snd_len,
    output logic              snd_ack,
    output logic              snd_busy,
    input  logic              snd_wvalid,
    input  logic [WORD_W-1:0] snd_wdata,
    output logic [NTILES-1:0] pend_mask,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    input  logic              notify_valid,
    input  logic [ID_W-1:0]   notify_src,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata,
    input  logic              req_gnt,
    input  logic              rsp_valid
);

    snd_state_e        state_q, state_d;
    logic [ID_W-1:0]   dest_q;
    logic [LEN_W-1:0]  len_q;
    logic [WIX_W-1:0]  cnt_q;
    logic [NTILES-1:0] pend_q;
    logic              last_word;

    assign snd_busy  = (state_q != SND_IDLE) || pend_q[snd_dest];
    assign snd_ack   = snd_req && !snd_busy;
    assign pend_mask = pend_q;
    assign last_word = ({1'b0, cnt_q} == len_q - LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SND_IDLE:   if (snd_ack)                 state_d = SND_LOAD;
            SND_LOAD:   if (snd_wvalid && last_word) state_d = SND_SIGNAL;
            SND_SIGNAL: if (req_gnt)                 state_d = SND_WAIT;
            SND_WAIT:   if (rsp_valid)               state_d = SND_IDLE;
            default:                                 state_d = SND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SND_IDLE;
            dest_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= (pend_q & ~(notify_valid ? (NTILES'(1) << notify_src) : '0))
                     | (snd_ack ? (NTILES'(1) << snd_dest) : '0);
            if (snd_ack) begin
                dest_q <= snd_dest;
                len_q  <= snd_len;
                cnt_q  <= '0;
            end else if (state_q == SND_LOAD && snd_wvalid) begin
                cnt_q  <= cnt_q + WIX_W'(1);
            end
        end
    end

    always_comb begin
        wr_en     = (state_q == SND_LOAD) && snd_wvalid;
        wr_idx    = {dest_q, cnt_q};
        wr_data   = snd_wdata;
        req_valid = (state_q == SND_SIGNAL);
        req_addr  = {dest_q, RGN_SEM, OFF_W'(tile_id)};
        req_wdata = WORD_W'(len_q);
    end

    AST_ACK_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        snd_ack |=> pend_mask[$past(snd_dest)]); // R2

    AST_SIGNAL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pend_mask[req_addr[ADDR_W-1 -: ID_W]]); // R3

endmodule

// File: rtl/msg_consumer.sv
module msg_consumer
    import msg_pkg::*;
#(
    parameter int NTILES = 16,
    parameter int WORD_W = 32,
    parameter int ID_W   = 4,
    parameter int WIX_W  = 4,
    parameter int LEN_W  = 5,
    parameter int OFF_W  = 8,
    parameter int ADDR_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         tile_id,
    input  logic                    rx_en,
    input  logic [NTILES-1:0]       sem_vec,
    input  logic [NTILES*LEN_W-1:0] hdr_len_flat,
    output logic                    sem_clr,
    output logic [ID_W-1:0]         sem_clr_idx,
    output logic                    req_valid,
    output logic                    req_write,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [WORD_W-1:0]       req_wdata,
    input  logic                    req_gnt,
    input  logic                    rsp_valid,
    input  logic [WORD_W-1:0]       rsp_rdata,
    output logic                    rx_valid,
    output logic [ID_W-1:0]         rx_src,
    output logic [WORD_W-1:0]       rx_data,
    output logic                    rx_last
);

    rcv_state_e       state_q, state_d;
    logic [ID_W-1:0]  src_q, last_q, pick;
    logic [LEN_W-1:0] len_q;
    logic [WIX_W-1:0] cnt_q;
    logic             found, start, last_word;
    logic [LEN_W-1:0] hdr_len [NTILES];

    for (genvar g = 0; g < NTILES; g++) begin : g_hdr
        assign hdr_len[g] = hdr_len_flat[g*LEN_W +: LEN_W];
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= NTILES; i++) begin
            logic [ID_W-1:0] kk;
            kk = ID_W'((int'(last_q) + i) % NTILES);
            if (!found && sem_vec[kk]) begin
                found = 1'b1;
                pick  = kk;
            end
        end
    end

    assign start     = (state_q == RCV_IDLE) && rx_en && found;
    assign last_word = ({1'b0, cnt_q} == len_q - LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RCV_IDLE:    if (start)     state_d = RCV_READ;
            RCV_READ:    if (req_gnt)   state_d = RCV_WAIT_RD;
            RCV_WAIT_RD: if (rsp_valid) state_d = last_word ? RCV_NOTIFY : RCV_READ;
            RCV_NOTIFY:  if (req_gnt)   state_d = RCV_WAIT_NT;
            RCV_WAIT_NT: if (rsp_valid) state_d = RCV_IDLE;
            default:                    state_d = RCV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RCV_IDLE;
            src_q    <= '0;
            last_q   <= ID_W'(NTILES - 1);
            len_q    <= '0;
            cnt_q    <= '0;
            rx_valid <= 1'b0;
            rx_src   <= '0;
            rx_data  <= '0;
            rx_last  <= 1'b0;
        end else begin
            state_q  <= state_d;
            rx_valid <= (state_q == RCV_WAIT_RD) && rsp_valid;
            if (start) begin
                src_q  <= pick;
                last_q <= pick;
                len_q  <= hdr_len[pick];
                cnt_q  <= '0;
            end
            if (state_q == RCV_WAIT_RD && rsp_valid) begin
                rx_src  <= src_q;
                rx_data <= rsp_rdata;
                rx_last <= last_word;
                cnt_q   <= cnt_q + WIX_W'(1);
            end
        end
    end

    always_comb begin
        sem_clr     = start;
        sem_clr_idx = pick;
        req_valid   = (state_q == RCV_READ) || (state_q == RCV_NOTIFY);
        req_write   = (state_q == RCV_NOTIFY);
        req_addr    = (state_q == RCV_NOTIFY) ? {src_q, RGN_NOTIFY, OFF_W'(tile_id)}
                                              : {src_q, RGN_OUTBOX, tile_id, cnt_q};
        req_wdata   = '0;
    end

    AST_LAST_THEN_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_last) |-> (state_q == RCV_NOTIFY)); // R8

    AST_MORE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_last) |-> (state_q == RCV_READ)); // R6

    AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RCV_IDLE && !rx_en) |=> (state_q == RCV_IDLE)); // R12

endmodule

// File: rtl/msg_net_mux.sv
module msg_net_mux #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_valid,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [WORD_W-1:0] p_wdata,
    output logic              p_gnt,
    output logic              p_rsp,
    input  logic              c_valid,
    input  logic              c_write,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [WORD_W-1:0] c_wdata,
    output logic              c_gnt,
    output logic              c_rsp,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata,
    input  logic              rsp_valid
);

    logic busy_q, owner_c_q;

    always_comb begin
        req_valid = !busy_q && (p_valid || c_valid);
        req_write = p_valid ? 1'b1    : c_write;
        req_addr  = p_valid ? p_addr  : c_addr;
        req_wdata = p_valid ? p_wdata : c_wdata;
        p_gnt     = !busy_q && req_ready && p_valid;
        c_gnt     = !busy_q && req_ready && !p_valid && c_valid;
        p_rsp     = rsp_valid && busy_q && !owner_c_q;
        c_rsp     = rsp_valid && busy_q && owner_c_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            owner_c_q <= 1'b0;
        end else if (p_gnt || c_gnt) begin
            busy_q    <= 1'b1;
            owner_c_q <= c_gnt;
        end else if (rsp_valid) begin
            busy_q    <= 1'b0;
        end
    end

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid); // R11

endmodule

// File: rtl/msg_engine.sv
module msg_engine
    import msg_pkg::*;
#(
    parameter int NTILES    = 16,
    parameter int MAX_WORDS = 16,
    parameter int WORD_W    = 32,
    localparam int ID_W     = $clog2(NTILES),
    localparam int WIX_W    = $clog2(MAX_WORDS),
    localparam int LEN_W    = WIX_W + 1,
    localparam int OFF_W    = ID_W + WIX_W,
    localparam int ADDR_W   = ID_W + 2 + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   tile_id,
    input  logic              snd_req,
    input  logic [ID_W-1:0]   snd_dest,
    input  logic [LEN_W-1:0]  snd_len,
    output logic              snd_ack,
    output logic              snd_busy,
    input  logic              snd_wvalid,
    input  logic [WORD_W-1:0] snd_wdata,
    output logic [NTILES-1:0] pend_mask,
    input  logic              rx_en,
    output logic              rx_valid,
    output logic [ID_W-1:0]   rx_src,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_last,
    output logic              ini_req_valid,
    input  logic              ini_req_ready,
    output logic              ini_req_write,
    output logic [ADDR_W-1:0] ini_req_addr,
    output logic [WORD_W-1:0] ini_req_wdata,
    input  logic              ini_rsp_valid,
    input  logic [WORD_W-1:0] ini_rsp_rdata,
    input  logic              tgt_valid,
    input  logic              tgt_write,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [WORD_W-1:0] tgt_wdata,
    output logic              tgt_rsp_valid,
    output logic [WORD_W-1:0] tgt_rsp_rdata
);

    logic                    wr_en;
    logic [OFF_W-1:0]        wr_idx;
    logic [WORD_W-1:0]       wr_data;
    logic [NTILES-1:0]       sem_vec;
    logic [NTILES*LEN_W-1:0] hdr_len_flat;
    logic                    sem_clr;
    logic [ID_W-1:0]         sem_clr_idx;
    logic                    notify_valid;
    logic [ID_W-1:0]         notify_src;
    logic                    p_valid, p_gnt, p_rsp;
    logic [ADDR_W-1:0]       p_addr;
    logic [WORD_W-1:0]       p_wdata;
    logic                    c_valid, c_write, c_gnt, c_rsp;
    logic [ADDR_W-1:0]       c_addr;
    logic [WORD_W-1:0]       c_wdata;

    msg_store #(
        .NTILES(NTILES), .MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W), .ID_W(ID_W),
        .LEN_W(LEN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .tgt_valid(tgt_valid), .tgt_write(tgt_write), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_rdata(tgt_rsp_rdata),
        .sem_vec(sem_vec), .hdr_len_flat(hdr_len_flat),
        .sem_clr(sem_clr), .sem_clr_idx(sem_clr_idx),
        .notify_valid(notify_valid), .notify_src(notify_src)
    );

    msg_producer #(
        .NTILES(NTILES), .WORD_W(WORD_W), .ID_W(ID_W), .WIX_W(WIX_W),
        .LEN_W(LEN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_producer (
        .clk(clk), .rst_n(rst_n), .tile_id(tile_id),
        .snd_req(snd_req), .snd_dest(snd_dest), .snd_len(snd_len),
        .snd_ack(snd_ack), .snd_busy(snd_busy),
        .snd_wvalid(snd_wvalid), .snd_wdata(snd_wdata), .pend_mask(pend_mask),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .notify_valid(notify_valid), .notify_src(notify_src),
        .req_valid(p_valid), .req_addr(p_addr), .req_wdata(p_wdata),
        .req_gnt(p_gnt), .rsp_valid(p_rsp)
    );

    msg_consumer #(
        .NTILES(NTILES), .WORD_W(WORD_W), .ID_W(ID_W), .WIX_W(WIX_W),
        .LEN_W(LEN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_consumer (
        .clk(clk), .rst_n(rst_n), .tile_id(tile_id), .rx_en(rx_en),
        .sem_vec(sem_vec), .hdr_len_flat(hdr_len_flat),
        .sem_clr(sem_clr), .sem_clr_idx(sem_clr_idx),
        .req_valid(c_valid), .req_write(c_write), .req_addr(c_addr), .req_wdata(c_wdata),
        .req_gnt(c_gnt), .rsp_valid(c_rsp), .rsp_rdata(ini_rsp_rdata),
        .rx_valid(rx_valid), .rx_src(rx_src), .rx_data(rx_data), .rx_last(rx_last)
    );

    msg_net_mux #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W)
    ) u_mux (
        .clk(clk), .rst_n(rst_n),
        .p_valid(p_valid), .p_addr(p_addr), .p_wdata(p_wdata), .p_gnt(p_gnt), .p_rsp(p_rsp),
        .c_valid(c_valid), .c_write(c_write), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_gnt(c_gnt), .c_rsp(c_rsp),
        .req_valid(ini_req_valid), .req_ready(ini_req_ready), .req_write(ini_req_write),
        .req_addr(ini_req_addr), .req_wdata(ini_req_wdata), .rsp_valid(ini_rsp_valid)
    );

endmodule

// File: tb/msg_engine_bench.sv
module msg_engine_bench;

    localparam logic [3:0] MY_ID = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tile_id = MY_ID;
    logic        snd_req = 1'b0;
    logic [3:0]  snd_dest = '0;
    logic [4:0]  snd_len = '0;
    logic        snd_ack, snd_busy;
    logic        snd_wvalid = 1'b0;
    logic [31:0] snd_wdata = '0;
    logic [15:0] pend_mask;
    logic        rx_en = 1'b1;
    logic        rx_valid, rx_last;
    logic [3:0]  rx_src;
    logic [31:0] rx_data;
    logic        ini_req_valid, ini_req_write;
    logic        ini_req_ready = 1'b1;
    logic [13:0] ini_req_addr;
    logic [31:0] ini_req_wdata;
    logic        ini_rsp_valid = 1'b0;
    logic [31:0] ini_rsp_rdata = '0;
    logic        tgt_valid = 1'b0, tgt_write = 1'b0;
    logic [13:0] tgt_addr = '0;
    logic [31:0] tgt_wdata = '0;
    logic        tgt_rsp_valid;
    logic [31:0] tgt_rsp_rdata;

    always #10 clk = ~clk;

    msg_engine u_msg_engine (
        .clk(clk), .rst_n(rst_n), .tile_id(tile_id),
        .snd_req(snd_req), .snd_dest(snd_dest), .snd_len(snd_len),
        .snd_ack(snd_ack), .snd_busy(snd_busy),
        .snd_wvalid(snd_wvalid), .snd_wdata(snd_wdata), .pend_mask(pend_mask),
        .rx_en(rx_en), .rx_valid(rx_valid), .rx_src(rx_src), .rx_data(rx_data), .rx_last(rx_last),
        .ini_req_valid(ini_req_valid), .ini_req_ready(ini_req_ready), .ini_req_write(ini_req_write),
        .ini_req_addr(ini_req_addr), .ini_req_wdata(ini_req_wdata),
        .ini_rsp_valid(ini_rsp_valid), .ini_rsp_rdata(ini_rsp_rdata),
        .tgt_valid(tgt_valid), .tgt_write(tgt_write), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_rdata(tgt_rsp_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [15:0] model_pend = '0;
    bit          exp_w[$];
    logic [13:0] exp_a[$];
    logic [31:0] exp_d[$];
    string       exp_t[$];
    logic [3:0]  rx_src_q[$];
    logic [31:0] rx_dat_q[$];
    bit          rx_last_q[$];

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] mk_addr(logic [3:0] t, logic [1:0] r, logic [7:0] o);
        return {t, r, o};
    endfunction

    function automatic logic [31:0] word_pat(logic [3:0] d, int i, int tag);
        return 32'h5000_0000 | (32'(tag) << 16) | (32'(d) << 8) | 32'(i);
    endfunction

    function automatic logic [31:0] remote_word(logic [13:0] a);
        return 32'hA000_0000 | 32'(a);
    endfunction

    // network model: checks each handshake, answers one cycle later
    logic        rsp_pend = 1'b0;
    logic [31:0] rsp_dat  = '0;
    always @(posedge clk) begin
        rsp_pend <= 1'b0;
        if (rst_n && ini_req_valid && ini_req_ready) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R4", "unexpected request addr", 64'(ini_req_addr), 64'h0);
            end else begin
                bit          ew;
                logic [13:0] ea;
                logic [31:0] ed;
                string       et;
                ew = exp_w.pop_front(); ea = exp_a.pop_front();
                ed = exp_d.pop_front(); et = exp_t.pop_front();
                check(ini_req_write == ew, et, "request kind", 64'(ini_req_write), 64'(ew));
                check(ini_req_addr == ea, et, "request addr", 64'(ini_req_addr), 64'(ea));
                if (ew) check(ini_req_wdata == ed, et, "request data", 64'(ini_req_wdata), 64'(ed));
            end
            rsp_pend <= 1'b1;
            rsp_dat  <= remote_word(ini_req_addr);
        end
    end

    always @(negedge clk) begin
        ini_rsp_valid = rsp_pend;
        ini_rsp_rdata = rsp_dat;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pend_mask == model_pend, "R2/R5", "pend_mask", 64'(pend_mask), 64'(model_pend));
            if (rx_valid) begin
                if (rx_src_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected rx word", 64'(rx_data), 64'h0);
                end else begin
                    logic [3:0]  es;
                    logic [31:0] ed;
                    bit          el;
                    es = rx_src_q.pop_front(); ed = rx_dat_q.pop_front(); el = rx_last_q.pop_front();
                    check(rx_src == es, "R7", "rx_src", 64'(rx_src), 64'(es));
                    check(rx_data == ed, "R7", "rx_data", 64'(rx_data), 64'(ed));
                    check(rx_last == el, "R7", "rx_last", 64'(rx_last), 64'(el));
                end
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1'b1;
            check(1'b0, "R11", "watchdog expired", 64'(wd), 64'd100000);
            summary();
        end
    end

    task automatic tgt_op(bit wr, logic [13:0] a, logic [31:0] wd_in, output logic [31:0] rd);
        @(negedge clk);
        tgt_valid = 1'b1; tgt_write = wr; tgt_addr = a; tgt_wdata = wd_in;
        @(negedge clk);
        tgt_valid = 1'b0; tgt_write = 1'b0;
        check(tgt_rsp_valid == 1'b1, "R10", "tgt_rsp_valid", 64'(tgt_rsp_valid), 64'd1);
        rd = tgt_rsp_rdata;
    endtask

    task automatic drain();
        for (int k = 0; k < 2000; k++) begin
            if (exp_a.size() == 0 && rx_src_q.size() == 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(exp_a.size() == 0, "R11", "requests still expected", 64'(exp_a.size()), 64'd0);
        check(rx_src_q.size() == 0, "R7", "rx words still expected", 64'(rx_src_q.size()), 64'd0);
    endtask

    task automatic try_refused(logic [3:0] d, string req);
        @(negedge clk);
        snd_req = 1'b1; snd_dest = d; snd_len = 5'd1;
        #1;
        check(snd_busy == 1'b1, req, "snd_busy", 64'(snd_busy), 64'd1);
        check(snd_ack == 1'b0, req, "snd_ack", 64'(snd_ack), 64'd0);
        @(negedge clk);
        snd_req = 1'b0;
    endtask

    task automatic do_send(logic [3:0] d, int len, int tag, bit probe_busy);
        @(negedge clk);
        snd_req = 1'b1; snd_dest = d; snd_len = 5'(len);
        #1;
        check(snd_ack == 1'b1 && snd_busy == 1'b0, "R2", "send accepted", 64'(snd_ack), 64'd1);
        exp_w.push_back(1'b1); exp_a.push_back(mk_addr(d, 2'd1, 8'(MY_ID)));
        exp_d.push_back(32'(len)); exp_t.push_back("R3");
        @(posedge clk);
        model_pend[d] = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            snd_wvalid = 1'b1; snd_wdata = word_pat(d, i, tag);
            if (i == 0 && probe_busy) begin
                snd_req = 1'b1; snd_dest = d + 4'd3; snd_len = 5'd1;
                #1;
                check(snd_busy == 1'b1 && snd_ack == 1'b0, "R4", "busy while loading",
                      64'(snd_ack), 64'd0);
            end else begin
                snd_req = 1'b0;
            end
        end
        @(negedge clk);
        snd_wvalid = 1'b0; snd_req = 1'b0;
        drain();
    endtask

    task automatic check_outbox(logic [3:0] d, int len, int tag, string req);
        for (int i = 0; i < len; i++) begin
            logic [31:0] rd;
            tgt_op(1'b0, mk_addr(MY_ID, 2'd0, {d, 4'(i)}), 32'h0, rd);
            check(rd == word_pat(d, i, tag), req, "outbox word", 64'(rd), 64'(word_pat(d, i, tag)));
        end
    endtask

    task automatic notify(logic [3:0] s);
        logic [31:0] rd;
        tgt_op(1'b1, mk_addr(MY_ID, 2'd2, 8'(s)), 32'h0, rd);
        model_pend[s] = 1'b0;
    endtask

    task automatic raise_sem(logic [3:0] s, int len);
        logic [31:0] rd;
        tgt_op(1'b1, mk_addr(MY_ID, 2'd1, 8'(s)), 32'(len), rd);
    endtask

    task automatic expect_pull(logic [3:0] s, int len);
        for (int i = 0; i < len; i++) begin
            logic [13:0] a;
            a = mk_addr(s, 2'd0, {MY_ID, 4'(i)});
            exp_w.push_back(1'b0); exp_a.push_back(a); exp_d.push_back(32'h0); exp_t.push_back("R6");
            rx_src_q.push_back(s); rx_dat_q.push_back(remote_word(a)); rx_last_q.push_back(i == len - 1);
        end
        exp_w.push_back(1'b1); exp_a.push_back(mk_addr(s, 2'd2, 8'(MY_ID)));
        exp_d.push_back(32'h0); exp_t.push_back("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pend_mask == 16'h0, "R1", "pend_mask", 64'(pend_mask), 64'h0);
        check(ini_req_valid == 1'b0, "R1", "ini_req_valid", 64'(ini_req_valid), 64'h0);
        check(rx_valid == 1'b0, "R1", "rx_valid", 64'(rx_valid), 64'h0);
        check(tgt_rsp_valid == 1'b0, "R1", "tgt_rsp_valid", 64'(tgt_rsp_valid), 64'h0);

        // R2 R3: send 3 words to tile 2, probing busy during load (R4)
        do_send(4'd2, 3, 1, 1'b1);
        check_outbox(4'd2, 3, 1, "R2");

        // R4: pending destination refused, outbox untouched
        try_refused(4'd2, "R4");
        repeat (4) @(negedge clk);
        check_outbox(4'd2, 3, 1, "R4");

        // R5: notification frees the slot, then a maximal 16-word message
        notify(4'd2);
        do_send(4'd2, 16, 2, 1'b0);
        check_outbox(4'd2, 16, 2, "R5");
        do_send(4'd11, 1, 3, 1'b0);
        check_outbox(4'd11, 1, 3, "R2");
        notify(4'd2);
        notify(4'd11);

        // R6 R7 R8: pull 4 words from tile 9
        expect_pull(4'd9, 4);
        raise_sem(4'd9, 4);
        drain();

        // R12: reception held off, then R9 round-robin order 1, 3, 9
        rx_en = 1'b0;
        raise_sem(4'd9, 1);
        raise_sem(4'd3, 2);
        raise_sem(4'd1, 1);
        repeat (6) @(negedge clk);
        check(exp_a.size() == 0 && ini_req_valid == 1'b0, "R12", "no request while disabled",
              64'(ini_req_valid), 64'd0);
        expect_pull(4'd1, 1);
        expect_pull(4'd3, 2);
        expect_pull(4'd9, 1);
        rx_en = 1'b1;
        drain();

        // R9: after serving 9, source 12 wins over 2
        rx_en = 1'b0;
        raise_sem(4'd2, 1);
        raise_sem(4'd12, 1);
        expect_pull(4'd12, 1);
        expect_pull(4'd2, 1);
        rx_en = 1'b1;
        drain();

        // R10 R11: long pull from tile 4 while remote reads hit this tile's outbox
        expect_pull(4'd4, 8);
        raise_sem(4'd4, 8);
        check_outbox(4'd2, 16, 2, "R10");
        drain();

        done = 1'b1;
        summary();
    end

endmodule